// File: doc/BRIEF.md
# Multiply-Accumulate Product Stage with Overflow Control

This block is the multiply stage that sits in front of an accumulator adder. It takes two 32-bit operands and one of three arithmetic modes: signed integer, unsigned integer or signed fraction. It forms the 64-bit product and aligns it so the adder can use it directly.

In the two integer modes the product is checked against a 40-bit accumulator range. Any overflow is merged into a sticky overflow flag. When saturation is enabled, an overflowed product is replaced by a sentinel value at bit 50. That sentinel is large enough that the following accumulate is certain to overflow as well. In fractional mode the product is shifted right by 24 bit positions. If rounding is requested, the dropped bits are rounded half-to-even.

Operands are captured on a valid strobe, and the aligned product and the updated flag appear together one cycle later. The adder, the accumulator registers and the status register itself are outside this block. The current overflow bit enters on `v_in` and the updated bit leaves on `v_out`.

Top module: `mac_mul_stage`

## Requirements
- R1: Inputs are captured on a rising clock edge where `in_valid` is high. On the next rising edge `out_valid` goes high for one cycle, with `result` and `v_out` for that transaction. `out_valid` is low in every other cycle.
- R2: While `out_valid` is low, `result` and `v_out` keep their previous values.
- R3: Signed integer mode (`mode` = 2'b00) forms the full two's-complement product. An overflow occurs when that product differs from its low 40 bits sign-extended to 64 bits. Without saturation the result is always those low 40 bits, sign-extended.
- R4: In signed integer mode with `sat_en` high, an overflowed product is replaced as follows. A negative product becomes the bitwise inverse of 2^50 (0xFFFB_FFFF_FFFF_FFFF). A non-negative product becomes 2^50 (0x0004_0000_0000_0000).
- R5: Unsigned integer mode (`mode` = 2'b01) forms the unsigned product. An overflow occurs when any of product bits 63..40 is set. Without saturation the result is the low 40 bits, zero-extended.
- R6: In unsigned integer mode with `sat_en` high, an overflowed product becomes 2^50.
- R7: Fractional mode (`mode` = 2'b10) forms the signed product and shifts it arithmetically right by 24 bits. With `round_en` low the 24 dropped bits are discarded.
- R8: In fractional mode with `round_en` high, the shifted value is adjusted by the 24 dropped bits. It is incremented when they exceed 0x800000. When they equal 0x800000 it is incremented only if its bit 0 is 1. Otherwise it is left as shifted.
- R9: `v_out` equals the captured `v_in` ORed with this transaction's overflow. A set `v_in` always gives a set `v_out`. Fractional mode never reports an overflow.
- R10: `mode` = 2'b11 behaves exactly like signed integer mode. `sat_en` has no effect in fractional mode, and `round_en` has no effect in either integer mode.
- R11: After reset `out_valid`, `result` and `v_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operand strobe |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| mode | input | 2 | 00 signed integer, 01 unsigned integer, 10 fractional, 11 signed integer |
| sat_en | input | 1 | Replace overflowed integer products with the sentinel |
| round_en | input | 1 | Round the dropped bits in fractional mode |
| v_in | input | 1 | Current sticky overflow bit |
| out_valid | output | 1 | Result strobe |
| result | output | 64 | Aligned product |
| v_out | output | 1 | Updated sticky overflow bit |

## Verification
The signed integer path is tested with these cases:
- small mixed-sign products, which must pass through unchanged;
- the exact 40-bit edges 2^39 and -2^39, which must overflow and fit respectively;
- large products of both signs, each with and without saturation, which separate the positive sentinel, the negative sentinel and the wrapped value.

The unsigned path is tested with:
- products that fill exactly 40 bits and must not overflow;
- a product of 2^40 and the largest operands, which must overflow and be either truncated or saturated.

The fractional path is tested with:
- dropped bits exactly at one half, where the kept value is even and where it is odd;
- dropped bits just above one half;
- negative products, where arithmetic shifting and the round-up interact.

Randomised traffic mixes all four mode codes with `v_in` set and clear, and with idle gaps that show the hold behaviour.

// File: rtl/mac_mul_pkg.sv
`timescale 1ns/1ps
package mac_mul_pkg;

  typedef enum logic [1:0] {
    MODE_SINT = 2'b00,
    MODE_UINT = 2'b01,
    MODE_FRAC = 2'b10,
    MODE_SALT = 2'b11
  } mul_mode_e;

  function automatic logic mode_is_unsigned(mul_mode_e m);
    return m == MODE_UINT;
  endfunction

  function automatic logic mode_is_frac(mul_mode_e m);
    return m == MODE_FRAC;
  endfunction

endpackage

// File: rtl/mac_mul_capture.sv
`timescale 1ns/1ps
module mac_mul_capture
  import mac_mul_pkg::*;
#(
  parameter int OP_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [OP_W-1:0] op_a,
  input  logic [OP_W-1:0] op_b,
  input  logic [1:0]      mode,
  input  logic            sat_en,
  input  logic            round_en,
  input  logic            v_in,
  output logic            s1_valid,
  output logic [OP_W-1:0] a_q,
  output logic [OP_W-1:0] b_q,
  output mul_mode_e       mode_q,
  output logic            sat_q,
  output logic            rnd_q,
  output logic            vin_q
);

  logic            valid_d;
  logic [OP_W-1:0] a_d, b_d;
  mul_mode_e       mode_d;
  logic            sat_d, rnd_d, vin_d;

  always_comb begin
    valid_d = in_valid;
    a_d     = a_q;
    b_d     = b_q;
    mode_d  = mode_q;
    sat_d   = sat_q;
    rnd_d   = rnd_q;
    vin_d   = vin_q;
    if (in_valid) begin
      a_d    = op_a;
      b_d    = op_b;
      mode_d = mul_mode_e'(mode);
      sat_d  = sat_en;
      rnd_d  = round_en;
      vin_d  = v_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      a_q      <= '0;
      b_q      <= '0;
      mode_q   <= MODE_SINT;
      sat_q    <= 1'b0;
      rnd_q    <= 1'b0;
      vin_q    <= 1'b0;
    end else begin
      s1_valid <= valid_d;
      a_q      <= a_d;
      b_q      <= b_d;
      mode_q   <= mode_d;
      sat_q    <= sat_d;
      rnd_q    <= rnd_d;
      vin_q    <= vin_d;
    end
  end

endmodule

// File: rtl/mac_mul_int.sv
`timescale 1ns/1ps
module mac_mul_int #(
  parameter int OP_W      = 32,
  parameter int GUARD_W   = 40,
  parameter int SAT_BIT   = 50,
  parameter int IS_SIGNED = 1,
  localparam int PROD_W   = 2 * OP_W
) (
  input  logic [OP_W-1:0]   a,
  input  logic [OP_W-1:0]   b,
  input  logic              sat_en,
  output logic [PROD_W-1:0] res,
  output logic              ovf
);

  localparam logic [PROD_W-1:0] SENTINEL = {{(PROD_W-1){1'b0}}, 1'b1} << SAT_BIT;

  logic              fill_a, fill_b;
  logic [PROD_W-1:0] ea, eb, prod, wrap, sat_val;

  always_comb begin
    fill_a = (IS_SIGNED != 0) ? a[OP_W-1] : 1'b0;
    fill_b = (IS_SIGNED != 0) ? b[OP_W-1] : 1'b0;
    ea     = {{OP_W{fill_a}}, a};
    eb     = {{OP_W{fill_b}}, b};
    prod   = ea * eb;
  end

  generate
    if (IS_SIGNED != 0) begin : g_signed
      always_comb begin
        ovf     = (|prod[PROD_W-1:GUARD_W-1]) & ~(&prod[PROD_W-1:GUARD_W-1]);
        wrap    = {{(PROD_W-GUARD_W){prod[GUARD_W-1]}}, prod[GUARD_W-1:0]};
        sat_val = prod[PROD_W-1] ? ~SENTINEL : SENTINEL;
      end
    end else begin : g_unsigned
      always_comb begin
        ovf     = |prod[PROD_W-1:GUARD_W];
        wrap    = {{(PROD_W-GUARD_W){1'b0}}, prod[GUARD_W-1:0]};
        sat_val = SENTINEL;
      end
    end
  endgenerate

  always_comb begin
    if (ovf) res = sat_en ? sat_val : wrap;
    else     res = prod;
  end

endmodule

// File: rtl/mac_mul_frac.sv
`timescale 1ns/1ps
module mac_mul_frac #(
  parameter int OP_W       = 32,
  parameter int FRAC_SHIFT = 24,
  localparam int PROD_W    = 2 * OP_W
) (
  input  logic [OP_W-1:0]   a,
  input  logic [OP_W-1:0]   b,
  input  logic              round_en,
  output logic [PROD_W-1:0] res
);

  localparam logic [FRAC_SHIFT-1:0] HALF = {1'b1, {(FRAC_SHIFT-1){1'b0}}};

  logic [PROD_W-1:0]     ea, eb, prod, shifted;
  logic [FRAC_SHIFT-1:0] rem;
  logic                  bump;

  always_comb begin
    ea      = {{OP_W{a[OP_W-1]}}, a};
    eb      = {{OP_W{b[OP_W-1]}}, b};
    prod    = ea * eb;
    shifted = $signed(prod) >>> FRAC_SHIFT;
    rem     = prod[FRAC_SHIFT-1:0];
    bump    = round_en & ((rem > HALF) | ((rem == HALF) & shifted[0]));
    res     = shifted + {{(PROD_W-1){1'b0}}, bump};
  end

endmodule

// File: rtl/mac_mul_stage.sv
`timescale 1ns/1ps
module mac_mul_stage
  import mac_mul_pkg::*;
#(
  parameter int OP_W       = 32,
  parameter int GUARD_W    = 40,
  parameter int FRAC_SHIFT = 24,
  parameter int SAT_BIT    = 50,
  localparam int RES_W     = 2 * OP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [OP_W-1:0]  op_a,
  input  logic [OP_W-1:0]  op_b,
  input  logic [1:0]       mode,
  input  logic             sat_en,
  input  logic             round_en,
  input  logic             v_in,
  output logic             out_valid,
  output logic [RES_W-1:0] result,
  output logic             v_out
);

  localparam logic [RES_W-1:0] SENTINEL = {{(RES_W-1){1'b0}}, 1'b1} << SAT_BIT;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic            s1_valid;
  logic [OP_W-1:0] a_q, b_q;
  mul_mode_e       mode_q;
  logic            sat_q, rnd_q, vin_q;

  mac_mul_capture #(.OP_W(OP_W)) u_capture (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .in_valid (in_valid),
    .op_a     (op_a),
    .op_b     (op_b),
    .mode     (mode),
    .sat_en   (sat_en),
    .round_en (round_en),
    .v_in     (v_in),
    .s1_valid (s1_valid),
    .a_q      (a_q),
    .b_q      (b_q),
    .mode_q   (mode_q),
    .sat_q    (sat_q),
    .rnd_q    (rnd_q),
    .vin_q    (vin_q)
  );

  // index 0: signed integer path, index 1: unsigned integer path
  logic [RES_W-1:0] int_res [2];
  logic             int_ovf [2];

  generate
    for (genvar gi = 0; gi < 2; gi++) begin : g_int
      mac_mul_int #(
        .OP_W      (OP_W),
        .GUARD_W   (GUARD_W),
        .SAT_BIT   (SAT_BIT),
        .IS_SIGNED ((gi == 0) ? 1 : 0)
      ) u_int (
        .a      (a_q),
        .b      (b_q),
        .sat_en (sat_q),
        .res    (int_res[gi]),
        .ovf    (int_ovf[gi])
      );
    end
  endgenerate

  logic [RES_W-1:0] frac_res;

  mac_mul_frac #(.OP_W(OP_W), .FRAC_SHIFT(FRAC_SHIFT)) u_frac (
    .a        (a_q),
    .b        (b_q),
    .round_en (rnd_q),
    .res      (frac_res)
  );

  logic [RES_W-1:0] sel_res, res_d;
  logic             sel_ovf, v_d, ov_d;

  always_comb begin
    if (mode_is_unsigned(mode_q)) begin
      sel_res = int_res[1];
      sel_ovf = int_ovf[1];
    end else if (mode_is_frac(mode_q)) begin
      sel_res = frac_res;
      sel_ovf = 1'b0;
    end else begin
      sel_res = int_res[0];
      sel_ovf = int_ovf[0];
    end
    ov_d  = s1_valid;
    res_d = s1_valid ? sel_res : result;
    v_d   = s1_valid ? (vin_q | sel_ovf) : v_out;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      v_out     <= 1'b0;
    end else begin
      out_valid <= ov_d;
      result    <= res_d;
      v_out     <= v_d;
    end
  end

  // R1: a capture strobe leads to an output strobe two edges later
  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> ##1 out_valid);

  // R1: no output strobe without a captured transaction
  p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !s1_valid |=> !out_valid);

  // R2: outputs hold between transactions
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !s1_valid |=> ($stable(result) && $stable(v_out)));

  // R3: unsaturated signed result always lies in the 40-bit range
  p_sint_range_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (s1_valid && (mode_q == MODE_SINT) && !sat_q)
      |=> ((&result[RES_W-1:GUARD_W-1]) || !(|result[RES_W-1:GUARD_W-1])));

  // R5: unsaturated unsigned result has no bits above the accumulator range
  p_uint_trunc_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (s1_valid && (mode_q == MODE_UINT) && !sat_q) |=> (result[RES_W-1:GUARD_W] == '0));

  // R6: saturated unsigned overflow leaves the sentinel
  p_uint_sat_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (s1_valid && (mode_q == MODE_UINT) && sat_q && int_ovf[1]) |=> (result == SENTINEL));

  // R9: a set incoming flag is never cleared
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (s1_valid && vin_q) |=> v_out);

  // R9: fractional transactions add no overflow
  p_frac_clean_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (s1_valid && (mode_q == MODE_FRAC) && !vin_q) |=> !v_out);

endmodule

// File: tb/mac_mul_stage_bench.sv
`timescale 1ns/1ps
module mac_mul_stage_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] op_a, op_b;
  logic [1:0]  mode;
  logic        sat_en, round_en, v_in;
  logic        out_valid;
  logic [63:0] result;
  logic        v_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  mac_mul_stage u_mac_mul_stage (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
    .op_a (op_a), .op_b (op_b), .mode (mode),
    .sat_en (sat_en), .round_en (round_en), .v_in (v_in),
    .out_valid (out_valid), .result (result), .v_out (v_out)
  );

  // two-deep expectation pipeline
  bit          e1_v, e2_v;
  logic [63:0] e1_r, e2_r;
  logic        e1_f, e2_f;
  string       e1_t, e2_t;
  logic [63:0] last_r = '0;
  logic        last_f = 1'b0;

  function automatic void model(input logic [31:0] a, input logic [31:0] b,
                                input logic [1:0] m, input logic s, input logic rnd,
                                input logic vi, output logic [63:0] r,
                                output logic f, output string tag);
    longint p, t, q;
    logic [63:0] pu, pb;
    logic [23:0] rem;
    logic ov;
    ov = 1'b0;
    if (m == 2'b01) begin
      pu = {32'b0, a} * {32'b0, b};
      ov = (pu[63:40] != 24'd0);
      r  = ov ? (s ? (64'd1 << 50) : {24'd0, pu[39:0]}) : pu;
      tag = s ? "R6" : "R5";
    end else if (m == 2'b10) begin
      p   = longint'($signed(a)) * longint'($signed(b));
      pb  = p;
      rem = pb[23:0];
      q   = p >>> 24;
      if (rnd && ((rem > 24'h800000) || ((rem == 24'h800000) && q[0]))) q = q + 1;
      r   = q;
      tag = rnd ? "R8" : "R7";
    end else begin
      p  = longint'($signed(a)) * longint'($signed(b));
      t  = (p <<< 24) >>> 24;
      ov = (t != p);
      if (ov && s) r = (p < 0) ? ~(64'd1 << 50) : (64'd1 << 50);
      else         r = t;
      tag = (m == 2'b11) ? "R10" : (ov && s) ? "R4" : "R3";
    end
    f = vi | ov;
  endfunction

  task automatic check_outputs();
    checks++;
    if (out_valid !== e2_v) begin
      errors++;
      $display("FAIL R1 out_valid actual %0b expected %0b", out_valid, e2_v);
    end
    if (e2_v) begin
      checks++;
      if (result !== e2_r) begin
        errors++;
        $display("FAIL %s result actual %h expected %h", e2_t, result, e2_r);
      end
      checks++;
      if (v_out !== e2_f) begin
        errors++;
        $display("FAIL R9 (%s) v_out actual %0b expected %0b", e2_t, v_out, e2_f);
      end
      last_r = e2_r;
      last_f = e2_f;
    end else begin
      checks++;
      if (result !== last_r || v_out !== last_f) begin
        errors++;
        $display("FAIL R2 hold actual %h/%0b expected %h/%0b", result, v_out, last_r, last_f);
      end
    end
  endtask

  task automatic step(input bit v, input logic [31:0] a, input logic [31:0] b,
                      input logic [1:0] m, input logic s, input logic rnd, input logic vi);
    @(negedge clk);
    check_outputs();
    e2_v = e1_v; e2_r = e1_r; e2_f = e1_f; e2_t = e1_t;
    e1_v = v;
    if (v) model(a, b, m, s, rnd, vi, e1_r, e1_f, e1_t);
    in_valid = v; op_a = a; op_b = b; mode = m; sat_en = s; round_en = rnd; v_in = vi;
  endtask

  task automatic idle();
    step(1'b0, $urandom, $urandom, 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_a = '0; op_b = '0; mode = '0;
    sat_en = 1'b0; round_en = 1'b0; v_in = 1'b0;
    e1_v = 0; e2_v = 0; e1_r = '0; e2_r = '0; e1_f = 0; e2_f = 0; e1_t = "R1"; e2_t = "R1";
    repeat (3) @(negedge clk);
    // R11: reset state
    checks++;
    if (out_valid !== 1'b0 || result !== 64'd0 || v_out !== 1'b0) begin
      errors++;
      $display("FAIL R11 reset actual %0b/%h/%0b expected 0/0/0", out_valid, result, v_out);
    end
    rst_n = 1'b1;
    repeat (4) idle();

    // R3: small mixed-sign products and 40-bit edges
    step(1, 32'd3, 32'hFFFF_FFFB, 2'b00, 0, 0, 0);
    step(1, 32'h0080_0000, 32'h0001_0000, 2'b00, 0, 0, 0);      // +2^39 overflows
    step(1, 32'hFF80_0000, 32'h0001_0000, 2'b00, 0, 0, 0);      // -2^39 fits
    step(1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 2'b00, 0, 0, 0);      // wrapped
    // R4: sentinels
    step(1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 2'b00, 1, 0, 0);
    step(1, 32'h8000_0000, 32'h7FFF_FFFF, 2'b00, 1, 0, 0);
    idle();
    // R5 / R6: unsigned edges
    step(1, 32'hFFFF_FFFF, 32'h0000_00FF, 2'b01, 0, 0, 0);
    step(1, 32'hFFFF_FFFF, 32'h0000_0100, 2'b01, 1, 0, 0);
    step(1, 32'h0001_0000, 32'h0100_0000, 2'b01, 0, 0, 0);
    step(1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b01, 1, 0, 0);
    // R7 / R8: fractional rounding corners
    step(1, 32'h0080_0000, 32'd1, 2'b10, 0, 1, 0);              // half, even
    step(1, 32'h0080_0000, 32'd3, 2'b10, 0, 1, 0);              // half, odd
    step(1, 32'h0080_0001, 32'd1, 2'b10, 0, 1, 0);              // above half
    step(1, 32'h0080_0000, 32'd3, 2'b10, 1, 0, 0);              // R10 sat ignored, no rounding
    step(1, 32'hFFFF_FFFF, 32'd1, 2'b10, 0, 1, 0);              // negative
    step(1, 32'h8000_0000, 32'h8000_0000, 2'b10, 0, 1, 1);      // R9 sticky through frac
    // R10: alias code and ignored rounding in integer modes
    step(1, 32'h8000_0000, 32'h7FFF_FFFF, 2'b11, 1, 1, 0);
    step(1, 32'd12345, 32'd678, 2'b01, 0, 1, 1);
    idle(); idle();

    // randomised traffic with gaps
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 3) == 0) idle();
      else step(1, $urandom, ($urandom_range(0, 1) != 0) ? $urandom : 32'($urandom_range(0, 65535)),
                2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    repeat (3) idle();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule